// File: doc/BRIEF.md
# Warp-Class Priority Memory Request Scheduler

This block sits between a shared cache and the DRAM controller of a throughput processor. Each incoming memory request carries a warp class code (how often the issuing warp tends to hit in the cache), a DRAM bank number, a row address and an identifier. Requests from warps that usually hit are steered into a small high-priority buffer. All other requests go to a separate low-priority buffer. One request per cycle is offered to DRAM over a valid/ready handshake.

The low-priority buffer is served only when the high-priority buffer is empty. Within the chosen buffer, a request whose row is already open in its bank wins over one that would need a new row. Among equal candidates, the request that has waited longest wins. The block keeps one open-row register per bank and loads it with the row of each request it issues. It models no DRAM timing. Buffer depths and the bank count are parameters.

Top module: `warp_prio_sched`

## Requirements
- R1: Class codes 0 (all-hit) and 1 (mostly-hit) are routed to the high-priority buffer. Codes 2 (balanced), 3 (mostly-miss) and 4 (all-miss) are routed to the low-priority buffer, as are the unused codes 5 to 7.
- R2: While the high-priority buffer holds any request, the offered request comes from it and `dram_hi` is 1. A low-priority request is offered, with `dram_hi` 0, only when the high-priority buffer is empty.
- R3: Within the selected buffer, a request is a row hit when its bank has a valid open row equal to the request's row. Any row hit is offered before any non-hit.
- R4: Among the row hits, or among all entries when none hits, the request accepted earliest is offered.
- R5: After reset no bank has an open row. Each completed issue loads the issued row into its bank's open-row register, and that register is used for selection from the next cycle on.
- R6: `req_ready` is 0 exactly when the buffer selected by the present `req_class` is full. A full buffer never blocks requests of the other group.
- R7: `dram_valid` is 1 whenever either buffer holds a request, and 0 otherwise. At most one request leaves per cycle, and it leaves on the clock edge where `dram_valid` and `dram_ready` are both 1. A request offered while `dram_ready` is 0 is not lost.
- R8: A synchronous active-low reset empties both buffers, so `dram_valid` is 0 and `req_ready` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | The buffer for this request's class has room |
| req_class | input | 3 | Warp class code of the request |
| req_bank | input | $clog2(NUM_BANKS) | DRAM bank of the request |
| req_row | input | ROW_W | DRAM row of the request |
| req_id | input | ID_W | Request identifier, carried through unchanged |
| dram_valid | output | 1 | A request is offered to DRAM |
| dram_ready | input | 1 | DRAM accepts the offered request |
| dram_bank | output | $clog2(NUM_BANKS) | Bank of the offered request |
| dram_row | output | ROW_W | Row of the offered request |
| dram_id | output | ID_W | Identifier of the offered request |
| dram_hi | output | 1 | Offered request comes from the high-priority buffer |

## Verification
The bench keeps only a few banks and rows in use, so row hits, misses and aging ties all occur often. It then checks every offered request against a queue-based reference. An ordering error, such as picking the youngest hit or ignoring the open row, shows up as a wrong `dram_id`. Directed runs fill the high-priority buffer while low-priority requests keep arriving. A design that applies back-pressure to both groups, or that drops a request offered while DRAM stalls, then fails on `req_ready` or on a missing identifier. Another run first opens a row and then queues an older miss behind a younger hit. This catches a design that updates the open row at the wrong time or serves the buffers in plain arrival order.

// File: rtl/warp_prio_sched_pkg.sv
// Shared definitions for the warp-class priority scheduler.
// Assumes the classifier upstream encodes warp classes on CLASS_W bits.
package warp_prio_sched_pkg;

    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        WC_ALL_HIT     = 3'd0,
        WC_MOSTLY_HIT  = 3'd1,
        WC_BALANCED    = 3'd2,
        WC_MOSTLY_MISS = 3'd3,
        WC_ALL_MISS    = 3'd4
    } warp_class_e;

endpackage

// File: rtl/psch_class_map.sv
// Maps a warp class code to its queue group.
// Assumes any code that is not a known high-priority class goes to the low group.
module psch_class_map
    import warp_prio_sched_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    output logic               is_hi
);

    // decide whether the class belongs to the high-priority group
    always_comb begin
        is_hi = (cls == WC_ALL_HIT) || (cls == WC_MOSTLY_HIT);
    end

endmodule

// File: rtl/psch_open_rows.sv
// Per-bank open-row table. Each bank register loads the row of each issued request.
// Assumes at most one update per cycle. After reset every bank is marked closed.
module psch_open_rows #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [BANK_W-1:0]    upd_bank,
    input  logic [ROW_W-1:0]     upd_row,
    output logic [NUM_BANKS-1:0] open_vld,
    output logic [ROW_W-1:0]     open_rows [NUM_BANKS]
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // record the row most recently issued to this bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_vld[b]  <= 1'b0;
                open_rows[b] <= '0;
            end else if (upd && (upd_bank == BANK_W'(b))) begin
                open_vld[b]  <= 1'b1;
                open_rows[b] <= upd_row;
            end
        end
    end

endmodule

// File: rtl/psch_queue.sv
// Searchable request buffer with FR-FCFS selection.
// Each entry's age equals the number of valid entries younger than it, so ages are
// unique and the oldest entry has the highest age. The selection prefers row hits,
// then the highest age. Assumes push is only raised when the buffer is not full.
module psch_queue #(
    parameter int DEPTH     = 4,
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 8,
    parameter int ID_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [BANK_W-1:0]    push_bank,
    input  logic [ROW_W-1:0]     push_row,
    input  logic [ID_W-1:0]      push_id,
    input  logic                 pop,
    input  logic [NUM_BANKS-1:0] open_vld,
    input  logic [ROW_W-1:0]     open_rows [NUM_BANKS],
    output logic                 full,
    output logic                 nonempty,
    output logic [BANK_W-1:0]    out_bank,
    output logic [ROW_W-1:0]     out_row,
    output logic [ID_W-1:0]      out_id
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int AGE_W = IDX_W;

    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  hit;
    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [AGE_W-1:0]  age_q  [DEPTH];

    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  pick_idx;
    logic [AGE_W-1:0]  pick_age;
    logic              pick_hit;
    logic              pick_found;

    // flag each valid entry whose row is open in its bank
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = vld_q[i] && open_vld[bank_q[i]] && (open_rows[bank_q[i]] == row_q[i]);
        end
    end

    // find the lowest-numbered empty slot
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IDX_W'(i);
        end
    end

    // pick a row hit first, and the oldest entry within that group
    always_comb begin
        pick_idx   = '0;
        pick_age   = '0;
        pick_hit   = 1'b0;
        pick_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i]) begin
                if (!pick_found || (hit[i] && !pick_hit) ||
                    ((hit[i] == pick_hit) && (age_q[i] > pick_age))) begin
                    pick_idx   = IDX_W'(i);
                    pick_age   = age_q[i];
                    pick_hit   = hit[i];
                    pick_found = 1'b1;
                end
            end
        end
    end

    assign full     = &vld_q;
    assign nonempty = |vld_q;
    assign out_bank = bank_q[pick_idx];
    assign out_row  = row_q[pick_idx];
    assign out_id   = id_q[pick_idx];

    // remove the picked entry on pop, write new entries, keep the age ranks exact
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (pop && (pick_idx == IDX_W'(i))) begin
                    vld_q[i] <= 1'b0;
                end else if (push && !vld_q[i] && (free_idx == IDX_W'(i))) begin
                    vld_q[i]  <= 1'b1;
                    age_q[i]  <= '0;
                    bank_q[i] <= push_bank;
                    row_q[i]  <= push_row;
                    id_q[i]   <= push_id;
                end else if (vld_q[i]) begin
                    age_q[i] <= age_q[i] + AGE_W'(push)
                                - AGE_W'(pop && (age_q[i] > pick_age));
                end
            end
        end
    end

endmodule

// File: rtl/warp_prio_sched.sv
// Two-group memory request scheduler. Each request is sorted by warp class into a
// high or a low buffer. The high buffer is served while it is not empty, and each
// buffer picks FR-FCFS against a per-bank open-row table. The offered request is
// chosen again every cycle, so a newly arrived high request can replace a low one
// that DRAM has not yet accepted.
module warp_prio_sched
    import warp_prio_sched_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int ID_W      = 8,
    parameter int HI_DEPTH  = 4,
    parameter int LO_DEPTH  = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CLASS_W-1:0] req_class,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [ID_W-1:0]    req_id,
    output logic               dram_valid,
    input  logic               dram_ready,
    output logic [BANK_W-1:0]  dram_bank,
    output logic [ROW_W-1:0]   dram_row,
    output logic [ID_W-1:0]    dram_id,
    output logic               dram_hi
);

    logic                 req_is_hi;
    logic                 hi_full, lo_full, hi_ne, lo_ne;
    logic                 push_hi, push_lo, pop_hi, pop_lo, issue;
    logic [BANK_W-1:0]    hi_bank, lo_bank;
    logic [ROW_W-1:0]     hi_row, lo_row;
    logic [ID_W-1:0]      hi_id, lo_id;
    logic [NUM_BANKS-1:0] open_vld;
    logic [ROW_W-1:0]     open_rows [NUM_BANKS];

    psch_class_map u_map (
        .cls   (req_class),
        .is_hi (req_is_hi)
    );

    // accept a request when its own group's buffer has room
    always_comb begin
        req_ready = req_is_hi ? !hi_full : !lo_full;
        push_hi   = req_valid && req_ready && req_is_hi;
        push_lo   = req_valid && req_ready && !req_is_hi;
    end

    // strict priority: the high buffer wins whenever it holds anything
    always_comb begin
        dram_valid = hi_ne || lo_ne;
        dram_hi    = hi_ne;
        dram_bank  = hi_ne ? hi_bank : lo_bank;
        dram_row   = hi_ne ? hi_row  : lo_row;
        dram_id    = hi_ne ? hi_id   : lo_id;
        issue      = dram_valid && dram_ready;
        pop_hi     = issue && hi_ne;
        pop_lo     = issue && !hi_ne;
    end

    psch_queue #(
        .DEPTH(HI_DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .ID_W(ID_W)
    ) u_hi_q (
        .clk(clk), .rst_n(rst_n),
        .push(push_hi), .push_bank(req_bank), .push_row(req_row), .push_id(req_id),
        .pop(pop_hi), .open_vld(open_vld), .open_rows(open_rows),
        .full(hi_full), .nonempty(hi_ne),
        .out_bank(hi_bank), .out_row(hi_row), .out_id(hi_id)
    );

    psch_queue #(
        .DEPTH(LO_DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .ID_W(ID_W)
    ) u_lo_q (
        .clk(clk), .rst_n(rst_n),
        .push(push_lo), .push_bank(req_bank), .push_row(req_row), .push_id(req_id),
        .pop(pop_lo), .open_vld(open_vld), .open_rows(open_rows),
        .full(lo_full), .nonempty(lo_ne),
        .out_bank(lo_bank), .out_row(lo_row), .out_id(lo_id)
    );

    psch_open_rows #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_rows (
        .clk(clk), .rst_n(rst_n),
        .upd(issue), .upd_bank(dram_bank), .upd_row(dram_row),
        .open_vld(open_vld), .open_rows(open_rows)
    );

endmodule

// File: rtl/warp_prio_sched_chk.sv
// Property checker for warp_prio_sched. It keeps its own count of requests held per
// group, taken only from the port handshakes, and checks priority, occupancy and
// back-pressure against those counts.
module warp_prio_sched_chk #(
    parameter int HI_DEPTH = 4,
    parameter int LO_DEPTH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_class,
    input logic       dram_valid,
    input logic       dram_ready,
    input logic       dram_hi
);

    logic [15:0] cnt_hi, cnt_lo;
    logic        in_hi;

    // group of the presented class, decoded from the code values
    always_comb in_hi = (req_class < 3'd2);

    // count requests held in each group from the port handshakes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_hi <= '0;
            cnt_lo <= '0;
        end else begin
            cnt_hi <= cnt_hi + 16'(req_valid && req_ready && in_hi)
                             - 16'(dram_valid && dram_ready && dram_hi);
            cnt_lo <= cnt_lo + 16'(req_valid && req_ready && !in_hi)
                             - 16'(dram_valid && dram_ready && !dram_hi);
        end
    end

    AST_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hi != 0) |-> (dram_valid && dram_hi)); // R2
    AST_HI_SOURCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_valid && dram_hi) |-> (cnt_hi != 0)); // R2
    AST_PENDING_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_hi + cnt_lo) != 0) |-> dram_valid); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_hi + cnt_lo) == 0) |-> !dram_valid); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hi <= 16'(HI_DEPTH)) && (cnt_lo <= 16'(LO_DEPTH))); // R6
    AST_HI_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hi && (cnt_hi == 16'(HI_DEPTH))) |-> !req_ready); // R6
    AST_LO_ROOM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hi && (cnt_lo < 16'(LO_DEPTH))) |-> req_ready); // R6
    AST_RESET_EMPTY: assert property (@(posedge clk)
        $rose(rst_n) |-> !dram_valid); // R8

endmodule

bind warp_prio_sched warp_prio_sched_chk #(
    .HI_DEPTH(HI_DEPTH), .LO_DEPTH(LO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .dram_valid(dram_valid), .dram_ready(dram_ready),
    .dram_hi(dram_hi)
);

// File: tb/warp_prio_sched_test.sv
`timescale 1ns/1ps
// Bench: queue-based reference model, directed corner cases and seeded random traffic.
module warp_prio_sched_test;

    localparam int NB = 4, HD = 4, LD = 8;

    typedef struct { int bank; int row; int id; } ment_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_class = '0;
    logic [1:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic [7:0] req_id = '0;
    logic       dram_valid;
    logic       dram_ready = 1'b0;
    logic [1:0] dram_bank;
    logic [7:0] dram_row;
    logic [7:0] dram_id;
    logic       dram_hi;

    int    n_chk = 0, n_bad = 0, next_id = 0;
    bit    done = 1'b0;
    ment_t mq_hi[$], mq_lo[$];
    int    orow[NB];
    bit    ovld[NB];

    always #2.5 clk = ~clk;

    warp_prio_sched uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_class(req_class), .req_bank(req_bank), .req_row(req_row), .req_id(req_id),
        .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_bank(dram_bank),
        .dram_row(dram_row), .dram_id(dram_id), .dram_hi(dram_hi)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // FR-FCFS reference: first row hit in arrival order, else the oldest
    function automatic int ref_pick(input ment_t q[$]);
        for (int i = 0; i < q.size(); i++)
            if (ovld[q[i].bank] && orow[q[i].bank] == q[i].row) return i;
        return 0;
    endfunction

    // one cycle: drive, compare against the model, then advance the model
    task automatic step(bit v, int cls, int bank, int row, bit drdy);
        bit    to_hi, exp_rdy, exp_valid, use_hi;
        int    idx;
        ment_t e;
        @(negedge clk);
        req_valid = v; req_class = 3'(cls); req_bank = 2'(bank);
        req_row = 8'(row); req_id = 8'(next_id); dram_ready = drdy;
        #1;
        to_hi   = (cls < 2);                                 // R1 grouping
        exp_rdy = to_hi ? (mq_hi.size() < HD) : (mq_lo.size() < LD);
        check("R6 req_ready", int'(req_ready), int'(exp_rdy));
        exp_valid = (mq_hi.size() + mq_lo.size()) > 0;
        check("R7 dram_valid", int'(dram_valid), int'(exp_valid));
        if (exp_valid) begin
            use_hi = mq_hi.size() > 0;
            idx = use_hi ? ref_pick(mq_hi) : ref_pick(mq_lo);
            e = use_hi ? mq_hi[idx] : mq_lo[idx];
            check("R1/R2 dram_hi", int'(dram_hi), int'(use_hi));
            check("R3/R4/R5 dram_id", int'(dram_id), e.id);
            check("R3/R5 dram_row", int'(dram_row), e.row);
            check("R3/R5 dram_bank", int'(dram_bank), e.bank);
            if (drdy) begin
                if (use_hi) mq_hi.delete(idx); else mq_lo.delete(idx);
                ovld[e.bank] = 1'b1;
                orow[e.bank] = e.row;
            end
        end
        if (v && exp_rdy) begin
            e.bank = bank; e.row = row; e.id = next_id & 8'hff;
            if (to_hi) mq_hi.push_back(e); else mq_lo.push_back(e);
            next_id++;
        end
    endtask

    task automatic drain(int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 1'b1);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin ovld[b] = 1'b0; orow[b] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check("R8 dram_valid in reset", int'(dram_valid), 0);
        check("R8 req_ready in reset", int'(req_ready), 1);
        @(negedge clk); rst_n = 1'b1;

        // R1: every class code while DRAM stalls, then drain; high ones leave first
        for (int c = 7; c >= 0; c--) step(1'b1, c, 0, 1, 1'b0);
        drain(10);

        // R6: overfill the high buffer; low requests must still be accepted
        for (int k = 0; k < 6; k++) step(1'b1, k % 2, 1, 2, 1'b0);
        step(1'b1, 3, 2, 4, 1'b0);
        step(1'b1, 0, 2, 4, 1'b0);
        drain(8);

        // R3 R4 R5: open bank 1 row 5, then older miss behind a younger hit
        step(1'b1, 2, 1, 5, 1'b1);
        drain(1);
        step(1'b1, 3, 1, 7, 1'b0);
        step(1'b1, 4, 1, 5, 1'b0);
        step(1'b1, 2, 1, 5, 1'b0);
        step(1'b1, 2, 2, 3, 1'b0);
        drain(5);

        // R7: stalled offer is held, then random traffic with small bank/row ranges
        step(1'b1, 1, 3, 0, 1'b0);
        step(1'b0, 0, 0, 0, 1'b0);
        drain(2);
        for (int k = 0; k < 4000; k++)
            step(($urandom % 10) < 7, $urandom % 8, $urandom % NB, $urandom % 4,
                 ($urandom % 10) < 6);
        drain(14);

        // R8: reset in the middle of traffic empties both buffers
        step(1'b1, 0, 0, 0, 1'b0);
        step(1'b1, 4, 0, 0, 1'b0);
        @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk); #1;
        check("R8 dram_valid after reset", int'(dram_valid), 0);
        check("R8 req_ready after reset", int'(req_ready), 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule